// File: doc/BRIEF.md
# Software Break Entry Sequencer

This block carries out the bus cycles of an 8-bit processor's software-break instruction. The cycle that fetches the opcode is not part of it. The surrounding core pulses `start` after that fetch. At the same moment it presents the current program counter, stack pointer and packed status byte. From then on the sequencer owns the single shared memory bus, one access per clock:

- a throw-away read at the program counter;
- the incremented return address, high byte then low byte, written into the stack page;
- the status byte, written into the stack page;
- the two bytes of the new program counter, read from a fixed vector.

When the sequence ends, the block raises `done` for one cycle. In that cycle it presents the new program counter, the lowered stack pointer, the status byte with interrupt-disable set, and the instruction's total cycle count. The core loads these values and resumes fetching at the vector target.

A parameter chooses between two behaviours for the throw-away access. With `STRICT` set, it is a real read. With `STRICT` cleared, the clock cycle is still spent but no read strobe is raised, which suits memories where a stray read has side effects.

Top module: `brk_entry_seq`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, the sequencer returns to idle. In idle, `busy`, `done`, `bus_rd` and `bus_wr` are all low, including when reset arrives in the middle of a sequence.
- R2: A `start` pulse in idle begins the sequence. In the first cycle after it, `bus_addr` equals the captured program counter, and with `STRICT`=1 `bus_rd` is high. The byte returned is discarded.
- R3: With `STRICT`=0, that first cycle still takes one clock but raises neither `bus_rd` nor `bus_wr`. The rest of the sequence is unchanged.
- R4: Cycles 2 and 3 are writes to address 0x0100 + SP. Cycle 2 writes bits 15:8 of (captured PC + 1) and cycle 3 writes bits 7:0. SP drops by one after each write.
- R5: Cycle 4 writes the captured status byte to 0x0100 + SP, with bit 4 and bit 5 forced to 1. The other bits are unchanged: C is bit 0, Z bit 1, I bit 2, D bit 3, V bit 6 and N bit 7. The I bit carries its old value.
- R6: Cycle 5 reads address 0xFFFE, which gives the low byte of the new PC. Cycle 6 reads address 0xFFFF, which gives the high byte.
- R7: Cycle 7 has `done` high for exactly one cycle and no bus strobe. In that cycle `pc_out` is the vector value, `sp_out` is the captured SP minus 3 (mod 256), and `status_out` is the pushed byte with bit 2 set.
- R8: `cycles_out` reads 7 while `done` is high, which counts the opcode fetch.
- R9: The stack pointer wraps within the stack page. A write at SP 0x00 goes to address 0x0100 and leaves SP at 0xFF.
- R10: A `start` pulse while `busy` is high has no effect, including in the `done` cycle. The bus sequence and the results are unchanged, and the block is idle in the cycle after `done`.
- R11: `bus_rd` and `bus_wr` are never high together, and each cycle raises at most one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin the sequence (accepted only when idle) |
| pc_in | input | 16 | Program counter, captured at start |
| sp_in | input | 8 | Stack pointer, captured at start |
| status_in | input | 8 | Packed status byte, captured at start |
| bus_rdata | input | 8 | Read data for the current bus cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| busy | output | 1 | High from the first sequence cycle through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter, valid with done |
| sp_out | output | 8 | Updated stack pointer, valid with done |
| status_out | output | 8 | Updated status byte, valid with done |
| cycles_out | output | 4 | Instruction cycle count, valid with done |

## Verification
The hardest situations to reach from the ports are a second `start` arriving mid-sequence or in the `done` cycle, and a stack pointer crossing from 0x00 to 0xFF between pushes. The stimulus places `start` pulses at chosen cycle offsets inside a running sequence. It also begins sequences with SP at 0x01 and 0x00, so the wrap falls between two pushes or on the first push. A program counter of 0xFFFF makes the return-address increment carry across both bytes. Reset is also applied in the middle of a sequence, and the following idle cycles are checked.

// File: rtl/brk_pkg.sv
// Shared types and constants for the software-break entry sequencer.
// Assumes an 8-bit status byte in which bit 2 is interrupt-disable.
package brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DUMMY   = 3'd1,
        ST_PUSH_HI = 3'd2,
        ST_PUSH_LO = 3'd3,
        ST_PUSH_P  = 3'd4,
        ST_VEC_LO  = 3'd5,
        ST_VEC_HI  = 3'd6,
        ST_DONE    = 3'd7
    } brk_state_t;

    localparam logic [7:0] STATUS_FORCE = 8'h30;  // bits 5 and 4 forced high
    localparam int         IRQ_DIS_BIT  = 2;

endpackage

// File: rtl/brk_ctrl.sv
// Sequence controller: steps through the fixed state order and counts
// instruction cycles. Assumes start is a level sampled only while idle.
module brk_ctrl #(
    parameter int CYC_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output brk_pkg::brk_state_t state_o,
    output logic [CYC_W-1:0]    cyc_o
);
    import brk_pkg::*;

    localparam logic [CYC_W-1:0] FIRST_CYC = CYC_W'(2);  // opcode fetch was cycle 1

    brk_state_t state_q, state_d;
    logic [CYC_W-1:0] cyc_q;

    // Next-state selection: a fixed chain, entered only from idle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_DUMMY;
            ST_DUMMY:   state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_PUSH_P;
            ST_PUSH_P:  state_d = ST_VEC_LO;
            ST_VEC_LO:  state_d = ST_VEC_HI;
            ST_VEC_HI:  state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State and cycle-count registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start)
                cyc_q <= FIRST_CYC;
            else if (state_d != ST_DONE && state_d != ST_IDLE)
                cyc_q <= cyc_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign cyc_o   = cyc_q;

endmodule

// File: rtl/brk_regs.sv
// Working registers: program counter, stack pointer and status byte.
// Captures the inputs at start, then updates them as each bus cycle completes.
module brk_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  brk_pkg::brk_state_t state,
    input  logic [ADDR_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]   sp_in,
    input  logic [DATA_W-1:0]   status_in,
    input  logic [DATA_W-1:0]   rdata,
    output logic [ADDR_W-1:0]   pc_q,
    output logic [DATA_W-1:0]   sp_q,
    output logic [DATA_W-1:0]   st_q
);
    import brk_pkg::*;

    localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(STATUS_FORCE);

    logic [DATA_W-1:0] vec_lo_q;

    // Register update per state; the stack pointer wraps naturally mod 2^DATA_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            sp_q     <= '0;
            st_q     <= '0;
            vec_lo_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc_q <= pc_in;
                        sp_q <= sp_in;
                        st_q <= status_in | FORCE_MASK;
                    end
                end
                ST_DUMMY:   pc_q <= pc_q + 1'b1;
                ST_PUSH_HI: sp_q <= sp_q - 1'b1;
                ST_PUSH_LO: sp_q <= sp_q - 1'b1;
                ST_PUSH_P: begin
                    sp_q              <= sp_q - 1'b1;
                    st_q[IRQ_DIS_BIT] <= 1'b1;
                end
                ST_VEC_LO:  vec_lo_q <= rdata;
                ST_VEC_HI:  pc_q     <= {rdata, vec_lo_q};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/brk_bus.sv
// Bus driver: derives address, strobes and write data from the current state.
// Purely combinational; assumes one access per clock.
module brk_bus #(
    parameter bit                STRICT     = 1'b1,
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] VECTOR     = 16'hFFFE
) (
    input  brk_pkg::brk_state_t state,
    input  logic [ADDR_W-1:0]   pc_q,
    input  logic [DATA_W-1:0]   sp_q,
    input  logic [DATA_W-1:0]   st_q,
    output logic [ADDR_W-1:0]   addr,
    output logic                rd,
    output logic                wr,
    output logic [DATA_W-1:0]   wdata
);
    import brk_pkg::*;

    localparam logic [ADDR_W-1:0] VECTOR_HI = VECTOR + 1'b1;

    logic [ADDR_W-1:0] stack_addr;

    assign stack_addr = {STACK_PAGE, sp_q};

    // Per-state bus decode.
    always_comb begin
        addr  = '0;
        rd    = 1'b0;
        wr    = 1'b0;
        wdata = '0;
        unique case (state)
            ST_DUMMY: begin
                addr = pc_q;
                rd   = STRICT;
            end
            ST_PUSH_HI: begin
                addr  = stack_addr;
                wr    = 1'b1;
                wdata = pc_q[ADDR_W-1:DATA_W];
            end
            ST_PUSH_LO: begin
                addr  = stack_addr;
                wr    = 1'b1;
                wdata = pc_q[DATA_W-1:0];
            end
            ST_PUSH_P: begin
                addr  = stack_addr;
                wr    = 1'b1;
                wdata = st_q;
            end
            ST_VEC_LO: begin
                addr = VECTOR;
                rd   = 1'b1;
            end
            ST_VEC_HI: begin
                addr = VECTOR_HI;
                rd   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/brk_entry_seq.sv
// Top of the software-break entry sequencer. Runs dummy read, three stack
// pushes and a two-byte vector fetch, then pulses done with the new state.
// Assumes the caller holds off other bus masters while busy is high.
module brk_entry_seq #(
    parameter bit STRICT = 1'b1,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] status_out,
    output logic [CYC_W-1:0]  cycles_out
);
    import brk_pkg::*;

    localparam logic [DATA_W-1:0] STACK_PAGE = DATA_W'(1);
    localparam logic [ADDR_W-1:0] VECTOR     = {{(ADDR_W-1){1'b1}}, 1'b0};

    brk_state_t        state;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] st_q;
    logic [CYC_W-1:0]  cyc;

    brk_ctrl #(.CYC_W(CYC_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .state_o (state),
        .cyc_o   (cyc)
    );

    brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .state     (state),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .status_in (status_in),
        .rdata     (bus_rdata),
        .pc_q      (pc_q),
        .sp_q      (sp_q),
        .st_q      (st_q)
    );

    brk_bus #(
        .STRICT     (STRICT),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STACK_PAGE (STACK_PAGE),
        .VECTOR     (VECTOR)
    ) u_bus (
        .state (state),
        .pc_q  (pc_q),
        .sp_q  (sp_q),
        .st_q  (st_q),
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wdata (bus_wdata)
    );

    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_DONE);
    assign pc_out     = pc_q;
    assign sp_out     = sp_q;
    assign status_out = st_q;
    assign cycles_out = cyc;

endmodule

// File: rtl/brk_entry_chk.sv
// Property checker for brk_entry_seq, attached by bind. Observes ports only.
module brk_entry_chk #(
    parameter bit STRICT = 1'b1,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] status_out,
    input logic [CYC_W-1:0]  cycles_out
);
    localparam logic [ADDR_W-1:0]     VEC_LO_A = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0]     VEC_HI_A = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-DATA_W-1:0] PAGE  = (ADDR_W-DATA_W)'(1);
    localparam logic [CYC_W-1:0]      TOTAL    = CYC_W'(7);
    localparam bit                    LAX      = !STRICT;

    // R11: one strobe at most per cycle
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R1: no strobes while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));

    // R4: pushes stay in the stack page
    a_r4_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr[ADDR_W-1:DATA_W] == PAGE));

    // R9: consecutive pushes step down by one, wrapping within the page
    a_r9_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(bus_wr)) |->
            (bus_addr[DATA_W-1:0] == DATA_W'($past(bus_addr[DATA_W-1:0]) - 1'b1)));

    // R6: vector low read is followed by vector high read
    a_r6_vec_order: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == VEC_LO_A && $past(bus_wr)) |=>
            (bus_rd && bus_addr == VEC_HI_A));

    // R7: done follows the vector high read, and lasts one cycle
    a_r7_done_after_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == VEC_HI_A && $past(bus_rd) && $past(bus_addr) == VEC_LO_A)
            |=> done);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: cycle count at completion
    a_r8_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles_out == TOTAL));

    // R5: forced bits and interrupt-disable set in the result
    a_r5_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status_out[2] && status_out[4] && status_out[5]));

    // R10: a running sequence is never cut short by start
    a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3: without strict mode the only reads are the vector bytes
    a_r3_no_dummy_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (LAX && bus_rd) |-> (bus_addr[ADDR_W-1:1] == VEC_LO_A[ADDR_W-1:1]));

endmodule

bind brk_entry_seq brk_entry_chk #(
    .STRICT (STRICT),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CYC_W  (CYC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .busy       (busy),
    .done       (done),
    .status_out (status_out),
    .cycles_out (cycles_out)
);

// File: tb/sim_brk_entry_seq.sv
// Bench: a behavioural per-cycle model drives expectations for a strict and a
// non-strict instance, compared at every falling edge.
module sim_brk_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  vlo = '0, vhi = '0;

    logic [15:0] a0, a1, pco0, pco1;
    logic        rd0, rd1, wr0, wr1, busy0, busy1, done0, done1;
    logic [7:0]  wd0, wd1, rdat0, rdat1, spo0, spo1, sto0, sto1;
    logic [3:0]  cyc0, cyc1;

    int nchecks = 0;
    int nfail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        if (a == 16'hFFFE)      return vlo;
        else if (a == 16'hFFFF) return vhi;
        else                    return a[7:0] ^ 8'h5A;
    endfunction

    always_comb rdat0 = mem_rd(a0);
    always_comb rdat1 = mem_rd(a1);

    brk_entry_seq #(.STRICT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .sp_in(sp_in),
        .status_in(status_in), .bus_rdata(rdat0), .bus_addr(a0), .bus_rd(rd0),
        .bus_wr(wr0), .bus_wdata(wd0), .busy(busy0), .done(done0), .pc_out(pco0),
        .sp_out(spo0), .status_out(sto0), .cycles_out(cyc0));

    brk_entry_seq #(.STRICT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .sp_in(sp_in),
        .status_in(status_in), .bus_rdata(rdat1), .bus_addr(a1), .bus_rd(rd1),
        .bus_wr(wr1), .bus_wdata(wd1), .busy(busy1), .done(done1), .pc_out(pco1),
        .sp_out(spo1), .status_out(sto1), .cycles_out(cyc1));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "u0 busy", busy0, 0);  chk(req, "u1 busy", busy1, 0);
        chk(req, "u0 rd", rd0, 0);      chk(req, "u1 rd", rd1, 0);
        chk(req, "u0 wr", wr0, 0);      chk(req, "u1 wr", wr1, 0);
        chk(req, "u0 done", done0, 0);  chk(req, "u1 done", done1, 0);
    endtask

    // One software-break sequence; restart_at != 0 pulses start at that cycle.
    task automatic run_brk(input logic [15:0] p, input logic [7:0] s,
                           input logic [7:0] t, input logic [7:0] lo,
                           input logic [7:0] hi, input int restart_at);
        logic [15:0] ret;
        logic [7:0]  sp_m;
        logic [15:0] e_addr;
        logic [7:0]  e_wd;
        bit          e_rd, e_wr;
        string       tag;
        vlo = lo; vhi = hi;
        pc_in = p; sp_in = s; status_in = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pc_in = ~p; sp_in = ~s; status_in = ~t;   // inputs must be captured
        ret  = p + 16'd1;
        sp_m = s;
        for (int k = 1; k <= 7; k++) begin
            e_rd = 0; e_wr = 0; e_addr = '0; e_wd = '0; tag = "R2";
            case (k)
                1: begin e_addr = p; e_rd = 1; tag = "R2"; end
                2: begin e_addr = {8'h01, sp_m}; e_wr = 1; e_wd = ret[15:8];
                         tag = (sp_m == 8'h00) ? "R9" : "R4"; end
                3: begin e_addr = {8'h01, sp_m}; e_wr = 1; e_wd = ret[7:0];
                         tag = (sp_m == 8'h00) ? "R9" : "R4"; end
                4: begin e_addr = {8'h01, sp_m}; e_wr = 1; e_wd = t | 8'h30;
                         tag = "R5"; end
                5: begin e_addr = 16'hFFFE; e_rd = 1; tag = "R6"; end
                6: begin e_addr = 16'hFFFF; e_rd = 1; tag = "R6"; end
                default: tag = "R7";
            endcase
            if (restart_at != 0 && k > restart_at) tag = "R10";
            chk(tag, "u0 busy", busy0, 1);
            chk(tag, "u0 rd", rd0, e_rd);
            chk(tag, "u0 wr", wr0, e_wr);
            chk(tag, "u1 wr", wr1, e_wr);
            chk((k == 1) ? "R3" : tag, "u1 rd", rd1, (k == 1) ? 0 : e_rd);
            chk("R11", "u0 rd&wr", rd0 & wr0, 0);
            if (k <= 6) begin
                chk(tag, "u0 addr", a0, e_addr);
                chk(tag, "u1 addr", a1, e_addr);
            end
            if (e_wr) begin
                chk(tag, "u0 wdata", wd0, e_wd);
                chk(tag, "u1 wdata", wd1, e_wd);
            end
            chk((k == 7) ? "R7" : tag, "u0 done", done0, (k == 7));
            chk((k == 7) ? "R7" : tag, "u1 done", done1, (k == 7));
            if (k == 7) begin
                chk("R7", "u0 pc_out", pco0, {hi, lo});
                chk("R7", "u1 pc_out", pco1, {hi, lo});
                chk((s < 8'd3) ? "R9" : "R7", "u0 sp_out", spo0, 8'(s - 8'd3));
                chk("R7", "u1 sp_out", spo1, 8'(s - 8'd3));
                chk("R5", "u0 status_out", sto0, t | 8'h34);
                chk("R5", "u1 status_out", sto1, t | 8'h34);
                chk("R8", "u0 cycles_out", cyc0, 7);
                chk("R8", "u1 cycles_out", cyc1, 7);
            end
            if (k >= 2 && k <= 4) sp_m = sp_m - 8'd1;
            start = (k == restart_at);
            @(negedge clk);
        end
        start = 1'b0;
        chk_idle("R10");   // idle right after done, even with a late start
        @(negedge clk);
        chk_idle("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchecks++; nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        run_brk(16'h1234, 8'hFD, 8'h00, 8'h34, 8'h12, 0);
        run_brk(16'hFFFF, 8'h80, 8'hC3, 8'h00, 8'h80, 3);   // carry across PC, restart mid-run
        run_brk(16'h7FFE, 8'h01, 8'hFF, 8'hAA, 8'h55, 7);   // SP wraps between pushes, start on done
        run_brk(16'h0000, 8'h00, 8'h41, 8'hFF, 8'hFF, 1);   // SP wraps on first push
        run_brk(16'hA5A5, 8'h40, 8'h89, 8'h01, 8'h02, 0);

        // R1: reset in the middle of a sequence
        pc_in = 16'h2222; sp_in = 8'h33; status_in = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        run_brk(16'h5000, 8'hFF, 8'h04, 8'h10, 8'h20, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule